// File: doc/BRIEF.md
# Serial NOR Flash Device Model

This block is a synthesizable model of a small serial flash as it appears to an SPI host. A command frame starts when chip select falls. The host shifts in bytes of 8 bits each: an opcode, a 24-bit address where the command needs one, and a data byte for programs. The model decodes read, byte-program, sector-erase, chip-erase, status and identification commands. It returns bytes on `miso` from an on-chip byte array whose depth is a parameter.

All pins are sampled in the `clk` domain, so SCK must run several clock periods per half cycle. This lets one model serve an SoC test harness or an FPGA prototype that stands in for a real flash part. Program and erase start a busy window whose lengths, in `clk` cycles, are parameters. The status byte reports busy or ready throughout that window. The opcode values, the ID byte values, the sector size and the array size are also parameters.

Top module: `spi_flash_model`

## Requirements
- R1: Every byte on `mosi` and `miso` is sent most-significant bit first. `mosi` is sampled on a rising SCK edge. `miso` changes only after a falling SCK edge or a change of `cs_n`. SCK may idle low (mode 0) or high (mode 3).
- R2: A falling `cs_n` starts a frame. A rising `cs_n` before a command's last byte is complete cancels that command, and nothing is written or erased.
- R3: Read (opcode 0x03, then three address bytes, high byte first) returns the byte at the address taken modulo the array size, and after it the following bytes in increasing order. After the top address the stream wraps to address 0. It continues until `cs_n` rises.
- R4: Byte program (opcode 0x02, three address bytes, one data byte) replaces the stored byte with the bitwise AND of the stored byte and the data. It takes effect once the eighth data bit is received.
- R5: Sector erase (opcode 0x20, three address bytes) sets every byte of the aligned sector that holds the address to 0xFF and leaves every other sector unchanged.
- R6: Chip erase (opcode 0x60) sets every byte of the array to 0xFF.
- R7: Status (opcode 0x05) returns a byte whose bits 7 to 1 are 0 and whose bit 0 is 0 while busy and 1 when ready. The byte repeats with its live value for as long as the frame continues.
- R8: The model is busy from each accepted program or erase until the programmed busy time and the erase sweep have both ended. A program or erase command that completes while the model is busy is ignored.
- R9: Identification (opcode 0x9F) returns a manufacturer byte (default 0xA5) and a device byte (default 0x3C), alternating and starting with the manufacturer byte.
- R10: While `rst_n` is low at a clock edge, any operation is aborted, busy clears and `miso` is 0. After `rst_n` is released, no command is taken until a new falling edge of `cs_n`.
- R11: `miso` is 0 while `cs_n` is high. After an unknown opcode, the rest of the frame is ignored and `miso` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; aborts any operation |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select; frames each command |
| mosi | input | 1 | Serial data into the model |
| miso | output | 1 | Serial data out of the model |

## Verification
On every cycle, the assertions check the following. `miso` moves only on a falling SCK or a chip-select change, and it is quiet while deselected. A program or erase start never coincides with busy, never coincides with the other kind of start, and always raises busy. Busy and `miso` are clear on leaving reset. Only the bench scenarios can show the data results: the byte values a read returns, wrap-around at the top address, AND-style programming, the extent of a sector erase, cancelled frames leaving the array untouched, the need for a fresh chip-select fall after reset, and both SCK idle levels.

// File: rtl/spi_flash_pkg.sv
// Shared types for the serial flash model.
// Assumes nothing beyond standard SystemVerilog enums.
package spi_flash_pkg;
    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_STATUS,
        ST_ID,
        ST_IGNORE
    } fl_state_t;

    typedef enum logic [1:0] {
        CK_READ,
        CK_PROG,
        CK_SERASE
    } fl_cmd_t;
endpackage

// File: rtl/spi_flash_shifter.sv
// Serial front end: detects SCK and chip-select edges in the clk domain,
// assembles MSB-first input bytes and shifts the output byte on SCK falls.
// Assumes SCK stays at each level for at least three clk periods.
module spi_flash_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       sck_fall,
    output logic       miso
);
    logic       sck_q;
    logic       cs_q;
    logic       sck_rise;
    logic [2:0] bit_cnt;
    logic [6:0] in_sr;
    logic [6:0] out_sr;

    assign cs_fall  = cs_q & ~cs_n;
    assign cs_rise  = ~cs_q & cs_n;
    assign sck_rise = ~cs_n & sck & ~sck_q;
    assign sck_fall = ~cs_n & ~sck & sck_q;

    // Previous-level registers for edge detection; reset copies the pins so no edge is seen on release.
    always_ff @(posedge clk) begin
        sck_q <= sck;
        cs_q  <= cs_n;
    end

    // Receive path: count bits and emit a one-cycle pulse per completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            bit_cnt  <= '0;
            in_sr    <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sck_rise) begin
                in_sr   <= {in_sr[5:0], mosi};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    // Byte capture register for the completed input byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte <= '0;
        end else if (!cs_n && sck_rise && bit_cnt == 3'd7) begin
            rx_byte <= {in_sr, mosi};
        end
    end

    // Transmit path: load a new byte on the fall at a byte boundary, else shift.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            miso   <= 1'b0;
            out_sr <= '0;
        end else if (sck_fall) begin
            if (bit_cnt == 3'd0) begin
                miso   <= tx_byte[7];
                out_sr <= tx_byte[6:0];
            end else begin
                miso   <= out_sr[6];
                out_sr <= {out_sr[5:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_flash_ctrl.sv
// Command sequencer: decodes opcodes, gathers the address, issues program
// and erase requests, and selects the byte to transmit for the active frame.
// Assumes ADDR_W is a multiple of 8 and AW does not exceed ADDR_W.
module spi_flash_ctrl
    import spi_flash_pkg::*;
#(
    parameter int          AW        = 11,
    parameter int          ADDR_W    = 24,
    parameter logic [7:0]  OP_READ   = 8'h03,
    parameter logic [7:0]  OP_PROG   = 8'h02,
    parameter logic [7:0]  OP_SERASE = 8'h20,
    parameter logic [7:0]  OP_CERASE = 8'h60,
    parameter logic [7:0]  OP_STATUS = 8'h05,
    parameter logic [7:0]  OP_ID     = 8'h9F,
    parameter logic [7:0]  MFR_ID    = 8'hA5,
    parameter logic [7:0]  DEV_ID    = 8'h3C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          busy,
    input  logic [7:0]    rd_data,
    output logic [7:0]    tx_byte,
    output logic [AW-1:0] rd_addr,
    output logic          prog_go,
    output logic          erase_go,
    output logic          erase_chip,
    output logic [AW-1:0] op_addr,
    output logic [7:0]    prog_data
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int ACW        = $clog2(ADDR_BYTES) + 1;

    fl_state_t       state;
    fl_cmd_t         kind;
    logic [AW-1:0]   addr_idx;
    logic [AW-1:0]   new_idx;
    logic [ACW-1:0]  addr_cnt;
    logic [AW-1:0]   ptr;
    logic            id_dev;

    assign new_idx = AW'({addr_idx, rx_byte});
    assign rd_addr = ptr;

    // Frame sequencer: reacts to chip-select edges and completed bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_STANDBY;
            kind       <= CK_READ;
            addr_idx   <= '0;
            addr_cnt   <= '0;
            ptr        <= '0;
            id_dev     <= 1'b0;
            prog_go    <= 1'b0;
            erase_go   <= 1'b0;
            erase_chip <= 1'b0;
            op_addr    <= '0;
            prog_data  <= '0;
        end else begin
            prog_go  <= 1'b0;
            erase_go <= 1'b0;
            if (cs_rise) begin
                state <= ST_STANDBY;
            end else if (cs_fall) begin
                state    <= ST_OPCODE;
                addr_cnt <= '0;
                id_dev   <= 1'b0;
            end else if (rx_valid) begin
                case (state)
                    ST_OPCODE: begin
                        case (rx_byte)
                            OP_READ:   begin state <= ST_ADDR; kind <= CK_READ;   end
                            OP_PROG:   begin state <= ST_ADDR; kind <= CK_PROG;   end
                            OP_SERASE: begin state <= ST_ADDR; kind <= CK_SERASE; end
                            OP_CERASE: begin
                                erase_go   <= !busy;
                                erase_chip <= 1'b1;
                                state      <= ST_IGNORE;
                            end
                            OP_STATUS: state <= ST_STATUS;
                            OP_ID:     state <= ST_ID;
                            default:   state <= ST_IGNORE;
                        endcase
                    end
                    ST_ADDR: begin
                        addr_idx <= new_idx;
                        addr_cnt <= addr_cnt + ACW'(1);
                        if (addr_cnt == ACW'(ADDR_BYTES - 1)) begin
                            ptr     <= new_idx;
                            op_addr <= new_idx;
                            case (kind)
                                CK_READ: state <= ST_READ;
                                CK_PROG: state <= ST_DATA;
                                default: begin
                                    erase_go   <= !busy;
                                    erase_chip <= 1'b0;
                                    state      <= ST_IGNORE;
                                end
                            endcase
                        end
                    end
                    ST_DATA: begin
                        prog_go   <= !busy;
                        prog_data <= rx_byte;
                        state     <= ST_IGNORE;
                    end
                    ST_READ: ptr    <= ptr + AW'(1);
                    ST_ID:   id_dev <= ~id_dev;
                    default: ;
                endcase
            end
        end
    end

    // Output byte selection for the shifter's next byte boundary.
    always_comb begin
        case (state)
            ST_READ:   tx_byte = rd_data;
            ST_STATUS: tx_byte = {7'b0000000, ~busy};
            ST_ID:     tx_byte = id_dev ? DEV_ID : MFR_ID;
            default:   tx_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/spi_flash_array.sv
// Byte array with busy timing: programs AND new data into a byte, erases by
// sweeping 0xFF over one byte per clk, and holds busy for the longer of the
// programmed time and the sweep. Assumes MEM_BYTES and SECTOR_BYTES are powers of two.
module spi_flash_array #(
    parameter int MEM_BYTES    = 2048,
    parameter int SECTOR_BYTES = 512,
    parameter int T_PROG       = 1000,
    parameter int T_SECT       = 1500,
    parameter int T_CHIP       = 4000,
    parameter int AW           = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic          prog_go,
    input  logic          erase_go,
    input  logic          erase_chip,
    input  logic [AW-1:0] op_addr,
    input  logic [7:0]    prog_data,
    output logic          busy
);
    localparam int T_MAX = (T_CHIP > T_SECT) ? ((T_CHIP > T_PROG) ? T_CHIP : T_PROG)
                                             : ((T_SECT > T_PROG) ? T_SECT : T_PROG);
    localparam int TW = $clog2(T_MAX + 1);
    localparam logic [AW-1:0] SEC_MASK = ~(AW'(SECTOR_BYTES - 1));

    logic [7:0]    mem [MEM_BYTES];
    logic [TW-1:0] timer;
    logic [AW:0]   sw_left;
    logic [AW-1:0] sw_ptr;

    assign busy    = (timer != '0) || (sw_left != '0);
    assign rd_data = mem[rd_addr];

    // Busy timer and erase sweep bookkeeping; reset aborts both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer   <= '0;
            sw_left <= '0;
            sw_ptr  <= '0;
        end else if (prog_go) begin
            timer <= TW'(T_PROG);
        end else if (erase_go) begin
            timer   <= erase_chip ? TW'(T_CHIP) : TW'(T_SECT);
            sw_ptr  <= erase_chip ? '0 : (op_addr & SEC_MASK);
            sw_left <= erase_chip ? (AW+1)'(MEM_BYTES) : (AW+1)'(SECTOR_BYTES);
        end else begin
            if (timer != '0) begin
                timer <= timer - TW'(1);
            end
            if (sw_left != '0) begin
                sw_left <= sw_left - (AW+1)'(1);
                sw_ptr  <= sw_ptr + AW'(1);
            end
        end
    end

    // Storage write port: one program or one erased byte per clk.
    always_ff @(posedge clk) begin
        if (prog_go) begin
            mem[op_addr] <= mem[op_addr] & prog_data;
        end else if (rst_n && sw_left != '0) begin
            mem[sw_ptr] <= 8'hFF;
        end
    end
endmodule

// File: rtl/spi_flash_model.sv
// Top level of the serial flash model: joins the serial front end, the
// command sequencer and the byte array. All pins are sampled in clk.
module spi_flash_model #(
    parameter int          ADDR_W       = 24,
    parameter int          MEM_BYTES    = 2048,
    parameter int          SECTOR_BYTES = 512,
    parameter int          T_PROG       = 1000,
    parameter int          T_SECT       = 1500,
    parameter int          T_CHIP       = 4000,
    parameter logic [7:0]  OP_READ      = 8'h03,
    parameter logic [7:0]  OP_PROG      = 8'h02,
    parameter logic [7:0]  OP_SERASE    = 8'h20,
    parameter logic [7:0]  OP_CERASE    = 8'h60,
    parameter logic [7:0]  OP_STATUS    = 8'h05,
    parameter logic [7:0]  OP_ID        = 8'h9F,
    parameter logic [7:0]  MFR_ID       = 8'hA5,
    parameter logic [7:0]  DEV_ID       = 8'h3C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    localparam int AW = $clog2(MEM_BYTES);

    logic          rx_valid;
    logic [7:0]    rx_byte;
    logic          cs_fall;
    logic          cs_rise;
    logic          sck_fall;
    logic [7:0]    tx_byte;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          prog_go;
    logic          erase_go;
    logic          erase_chip;
    logic [AW-1:0] op_addr;
    logic [7:0]    prog_data;
    logic          busy;

    spi_flash_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .tx_byte  (tx_byte),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_fall (sck_fall),
        .miso     (miso)
    );

    spi_flash_ctrl #(
        .AW        (AW),
        .ADDR_W    (ADDR_W),
        .OP_READ   (OP_READ),
        .OP_PROG   (OP_PROG),
        .OP_SERASE (OP_SERASE),
        .OP_CERASE (OP_CERASE),
        .OP_STATUS (OP_STATUS),
        .OP_ID     (OP_ID),
        .MFR_ID    (MFR_ID),
        .DEV_ID    (DEV_ID)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .busy       (busy),
        .rd_data    (rd_data),
        .tx_byte    (tx_byte),
        .rd_addr    (rd_addr),
        .prog_go    (prog_go),
        .erase_go   (erase_go),
        .erase_chip (erase_chip),
        .op_addr    (op_addr),
        .prog_data  (prog_data)
    );

    spi_flash_array #(
        .MEM_BYTES    (MEM_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES),
        .T_PROG       (T_PROG),
        .T_SECT       (T_SECT),
        .T_CHIP       (T_CHIP),
        .AW           (AW)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .prog_go    (prog_go),
        .erase_go   (erase_go),
        .erase_chip (erase_chip),
        .op_addr    (op_addr),
        .prog_data  (prog_data),
        .busy       (busy)
    );
endmodule

// File: rtl/spi_flash_checker.sv
// Cycle-level properties of the serial flash model, bound to its top level.
// Assumes the signal names of spi_flash_model.
module spi_flash_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic miso,
    input logic sck_fall,
    input logic prog_go,
    input logic erase_go,
    input logic busy
);
    // R1: the output bit moves only after an SCK fall or a chip-select change.
    assert_miso_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(miso)) |-> ($past(cs_n) || $past(sck_fall)));

    // R11: a deselected model drives 0.
    assert_miso_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !miso);

    // R8: requests reach the array only when it is ready.
    assert_go_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_go || erase_go) |-> !busy);

    // R8: every accepted request makes the array busy.
    assert_go_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_go || erase_go) |=> busy);

    // R4: program and erase requests never coincide.
    assert_go_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_go, erase_go}));

    // R10: leaving reset finds the model idle and quiet.
    assert_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !miso));
endmodule

bind spi_flash_model spi_flash_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .miso     (miso),
    .sck_fall (sck_fall),
    .prog_go  (prog_go),
    .erase_go (erase_go),
    .busy     (busy)
);

// File: tb/spi_flash_model_test.sv
// Self-checking bench for the serial flash model: a vector table of
// program/read pairs, then directed tests for erase, status, ID, aborts and reset.
module spi_flash_model_test;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int checks = 0;
    int errors = 0;
    bit mode3 = 1'b0;
    bit done = 1'b0;
    logic [7:0] rb;
    logic [7:0] rbuf [4];

    // {mode3, address, program data, expected read}
    localparam logic [32:0] VECS [6] = '{
        {1'b0, 16'h0010, 8'h5A, 8'h5A},
        {1'b1, 16'h0010, 8'hF0, 8'h50},
        {1'b0, 16'h07FF, 8'h81, 8'h81},
        {1'b1, 16'h0000, 8'h3C, 8'h3C},
        {1'b0, 16'h0200, 8'h00, 8'h00},
        {1'b1, 16'h0201, 8'h7E, 8'h7E}
    };

    spi_flash_model uut (
        .clk  (clk),
        .rst_n(rst_n),
        .sck  (sck),
        .cs_n (cs_n),
        .mosi (mosi),
        .miso (miso)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_open();
        sck = mode3;
        wait_clk(2);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic frame_close();
        if (!mode3) begin
            sck = 1'b0;
            wait_clk(HALF);
        end
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic xfer_bits(input logic [7:0] o, input int nbits, output logic [7:0] i);
        i = 8'h00;
        for (int b = 7; b > 7 - nbits; b--) begin
            sck = 1'b0;
            mosi = o[b];
            wait_clk(HALF);
            i[b] = miso;
            sck = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic xfer(input logic [7:0] o, output logic [7:0] i);
        xfer_bits(o, 8, i);
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] d;
        xfer(a[23:16], d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
    endtask

    task automatic do_prog(input logic [23:0] a, input logic [7:0] v);
        logic [7:0] d;
        frame_open();
        xfer(8'h02, d);
        send_addr(a);
        xfer(v, d);
        frame_close();
    endtask

    task automatic do_serase(input logic [23:0] a);
        logic [7:0] d;
        frame_open();
        xfer(8'h20, d);
        send_addr(a);
        frame_close();
    endtask

    task automatic do_cerase();
        logic [7:0] d;
        frame_open();
        xfer(8'h60, d);
        frame_close();
    endtask

    task automatic do_read(input logic [23:0] a, input int n);
        logic [7:0] d;
        frame_open();
        xfer(8'h03, d);
        send_addr(a);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, d);
            rbuf[k] = d;
        end
        frame_close();
    endtask

    task automatic wait_ready();
        logic [7:0] d;
        int tries;
        tries = 0;
        frame_open();
        xfer(8'h05, d);
        d = 8'h00;
        while (d[0] !== 1'b1 && tries < 400) begin
            xfer(8'h00, d);
            tries++;
        end
        frame_close();
        chk("R8 ready reached", {31'd0, d[0]}, 32'd1);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int cnt;
        wait_clk(5);
        chk("R10 miso low in reset", {31'd0, miso}, 32'd0);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R11 miso low deselected", {31'd0, miso}, 32'd0);

        // R6 and R7: chip erase, then a single continuous status frame
        do_cerase();
        frame_open();
        xfer(8'h05, d);
        xfer(8'h00, d);
        chk("R7 status busy", {24'd0, d}, 32'h00);
        cnt = 0;
        while (d !== 8'h01 && cnt < 400) begin
            xfer(8'h00, d);
            cnt++;
        end
        frame_close();
        chk("R7 status turns ready within frame", {24'd0, d}, 32'h01);
        do_read(24'h000000, 1);
        chk("R6 erased low byte", {24'd0, rbuf[0]}, 32'hFF);
        do_read(24'h0007FF, 1);
        chk("R6 erased top byte", {24'd0, rbuf[0]}, 32'hFF);

        // R1/R4 vector table, alternating SCK idle levels
        foreach (VECS[v]) begin
            mode3 = VECS[v][32];
            do_prog({8'h00, VECS[v][31:16]}, VECS[v][15:8]);
            wait_ready();
            do_read({8'h00, VECS[v][31:16]}, 1);
            chk($sformatf("R4 R1 vector %0d", v), {24'd0, rbuf[0]}, {24'd0, VECS[v][7:0]});
        end
        mode3 = 1'b0;

        // R3: wrap at top, stream increment, high address bits ignored
        do_read(24'h0007FF, 2);
        chk("R3 top byte", {24'd0, rbuf[0]}, 32'h81);
        chk("R3 wrap to zero", {24'd0, rbuf[1]}, 32'h3C);
        mode3 = 1'b1;
        do_read(24'h000010, 2);
        chk("R3 stream first", {24'd0, rbuf[0]}, 32'h50);
        chk("R3 stream next", {24'd0, rbuf[1]}, 32'hFF);
        mode3 = 1'b0;
        do_read(24'h0A0010, 1);
        chk("R3 high address bits", {24'd0, rbuf[0]}, 32'h50);

        // R8: second program while busy is ignored; status busy right after
        do_prog(24'h000020, 8'h11);
        do_prog(24'h000021, 8'h00);
        frame_open();
        xfer(8'h05, d);
        xfer(8'h00, d);
        frame_close();
        chk("R8 busy after program", {24'd0, d}, 32'h00);
        wait_ready();
        do_read(24'h000020, 2);
        chk("R4 first program", {24'd0, rbuf[0]}, 32'h11);
        chk("R8 program while busy ignored", {24'd0, rbuf[1]}, 32'hFF);

        // R5: sector erase, plus program while erasing ignored
        do_serase(24'h000280);
        do_prog(24'h000300, 8'h00);
        wait_ready();
        do_read(24'h000200, 2);
        chk("R5 sector byte 0", {24'd0, rbuf[0]}, 32'hFF);
        chk("R5 sector byte 1", {24'd0, rbuf[1]}, 32'hFF);
        do_read(24'h000300, 1);
        chk("R8 program during erase ignored", {24'd0, rbuf[0]}, 32'hFF);
        do_read(24'h000010, 1);
        chk("R5 other sector kept", {24'd0, rbuf[0]}, 32'h50);
        do_read(24'h0007FF, 1);
        chk("R5 far sector kept", {24'd0, rbuf[0]}, 32'h81);

        // R9: identification bytes alternate
        frame_open();
        xfer(8'h9F, d);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, d);
            rbuf[k] = d;
        end
        frame_close();
        chk("R9 manufacturer", {24'd0, rbuf[0]}, 32'hA5);
        chk("R9 device", {24'd0, rbuf[1]}, 32'h3C);
        chk("R9 repeat", {24'd0, rbuf[2]}, 32'hA5);

        // R7: ready status repeats
        frame_open();
        xfer(8'h05, d);
        xfer(8'h00, rbuf[0]);
        xfer(8'h00, rbuf[1]);
        frame_close();
        chk("R7 ready byte", {24'd0, rbuf[0]}, 32'h01);
        chk("R7 ready repeats", {24'd0, rbuf[1]}, 32'h01);

        // R2: program cut after 4 data bits, erase cut after 2 address bytes
        frame_open();
        xfer(8'h02, d);
        send_addr(24'h000040);
        xfer_bits(8'h00, 4, d);
        frame_close();
        frame_open();
        xfer(8'h20, d);
        xfer(8'h00, d);
        xfer(8'h00, d);
        frame_close();
        frame_open();
        xfer(8'h05, d);
        xfer(8'h00, d);
        frame_close();
        chk("R2 cancelled commands leave ready", {24'd0, d}, 32'h01);
        do_read(24'h000040, 1);
        chk("R2 cancelled program", {24'd0, rbuf[0]}, 32'hFF);
        do_read(24'h000010, 1);
        chk("R2 cancelled erase", {24'd0, rbuf[0]}, 32'h50);

        // R11: unknown opcode swallows the rest of the frame
        frame_open();
        xfer(8'hAB, d);
        xfer(8'h02, d);
        chk("R11 miso after unknown opcode", {24'd0, d}, 32'h00);
        send_addr(24'h000050);
        xfer(8'h00, d);
        frame_close();
        wait_clk(20);
        do_read(24'h000050, 1);
        chk("R11 embedded program ignored", {24'd0, rbuf[0]}, 32'hFF);

        // R10: reset mid-erase with chip select held low
        do_cerase();
        frame_open();
        wait_clk(100);
        rst_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        xfer(8'h05, d);
        xfer(8'h00, d);
        chk("R10 no command without new cs fall", {24'd0, d}, 32'h00);
        frame_close();
        frame_open();
        xfer(8'h05, d);
        xfer(8'h00, d);
        frame_close();
        chk("R10 reset aborts erase", {24'd0, d}, 32'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule